// File: doc/BRIEF.md
# Byte-Parallel CRC16 Check Peripheral

This peripheral keeps a 16-bit cyclic redundancy code with the generator x^16 + x^12 + x^5 + 1 and sits on a small byte-wide register bus. A test environment or a controller streams message bytes into it. Each write folds one whole byte into the register in a single clock, and a read returns the running code one byte at a time. Writing to a dedicated address restarts the computation from the all-ones seed. There is no final inversion.

A second write port takes a code that was produced elsewhere. Its bits are fed in the opposite order, most significant first, high byte before low byte. The usual use is to stream a message and then its expected code into this port. The register then ends at zero when nothing was corrupted and at a nonzero value otherwise.

The next-state logic is the serial shift register unrolled eight times. The shift register works as follows: the feedback bit is the register MSb XORed with the incoming bit, it enters bit 0, and it is also XORed into bits 5 and 12.

Top module: `crc16_port_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the register becomes 0xFFFF on that edge.
- R2: A write (`bus_en`=1, `bus_we`=1) to address 0 sets the register to 0xFFFF on the next edge, whatever its previous value.
- R3: A write to address 2 or 3 folds `bus_wdata` into the register in one clock. Bit 0 of the byte enters first and bit 7 enters last. Each serial step computes fb = reg[15] ^ bit, then reg = (reg << 1) ^ (fb ? 0x1021 : 0).
- R4: A write to address 4 folds `bus_wdata` using the same serial step but with bit 7 entering first and bit 0 last. If the byte equals the register's high byte, the result is the old low byte moved into the high byte with a zero low byte.
- R5: After a message has been written to the data port, writing the resulting code to address 4, high byte then low byte, leaves the register at 0x0000.
- R6: A read (`bus_en`=1, `bus_we`=0) of address 2 returns register bits 7:0, and a read of address 3 returns bits 15:8. Both appear combinationally in the same cycle, and a read leaves the register unchanged.
- R7: The register holds its value on every cycle with no write to address 0, 2, 3 or 4. This includes writes to unmapped addresses and cycles with `bus_en` low.
- R8: If any single bit of a message is flipped and the code of the unflipped message is then written to address 4, the register ends at a nonzero value.
- R9: `bus_rdata` is 0x00 whenever the cycle is not a read of address 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (3) | Port address |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, combinational |

## Verification
The bench builds the block with its default parameters: a 3-bit address, ports at 0, 2/3 and 4, polynomial 0x1021 and seed 0xFFFF. With the 3-bit address, the whole address space can be walked, so every unmapped address gets a write that must be ignored. The default polynomial and seed let the zero residue of appended codes be checked as an absolute value. All 32 single-bit corruptions of a four-byte message are also run, so a wrong tap or a wrong bit order within a byte shows up as a residue mismatch.

// File: rtl/crc16_pkg.sv
`timescale 1ns/1ps
// Shared types for the CRC16 peripheral.
// Assumes a byte-wide bus and a 16-bit code register.
package crc16_pkg;
    localparam int CRC_W  = 16;
    localparam int BYTE_W = 8;

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Decoded bus operation that changes the register
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_DATA  = 2'd2,
        OP_CHECK = 2'd3
    } crc_op_e;
endpackage

// File: rtl/crc16_bus_decode.sv
`timescale 1ns/1ps
// Address decoder: turns one bus access into a register operation and
// byte-lane read selects. Assumes DAT_ADDR is even; its pair DAT_ADDR+1
// is the high byte. All other addresses are ignored.
module crc16_bus_decode
    import crc16_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int CLR_ADDR = 0,
    parameter int DAT_ADDR = 2,
    parameter int CHK_ADDR = 4
) (
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output crc_op_e           op,
    output logic              rd_lo,
    output logic              rd_hi
);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(CLR_ADDR);
    localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(DAT_ADDR);
    localparam logic [ADDR_W-1:0] A_CHK = ADDR_W'(CHK_ADDR);

    logic dat_hit;
    assign dat_hit = (addr[ADDR_W-1:1] == A_DAT[ADDR_W-1:1]);

    // Classify write accesses into register operations
    always_comb begin
        op = OP_NONE;
        if (en && we) begin
            if (addr == A_CLR)     op = OP_CLEAR;
            else if (dat_hit)      op = OP_DATA;
            else if (addr == A_CHK) op = OP_CHECK;
        end
    end

    // Select the byte lane for reads of the data pair
    always_comb begin
        rd_lo = en && !we && dat_hit && !addr[0];
        rd_hi = en && !we && dat_hit &&  addr[0];
    end
endmodule

// File: rtl/crc16_byte_fold.sv
`timescale 1ns/1ps
// Combinational byte fold: eight serial shift-register steps unrolled
// into one level of XOR equations. MSB_FIRST selects the bit order
// within the byte. Assumes POLY omits the implicit x^16 term.
module crc16_byte_fold
    import crc16_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY      = 16'h1021,
    parameter bit               MSB_FIRST = 1'b0
) (
    input  crc_t  crc_in,
    input  byte_t byte_in,
    output crc_t  crc_out
);
    logic [BYTE_W:0][CRC_W-1:0] stage;
    logic [BYTE_W-1:0]          fb;

    assign stage[0] = crc_in;

    for (genvar k = 0; k < BYTE_W; k++) begin : g_step
        localparam int BIT_IDX = MSB_FIRST ? (BYTE_W-1-k) : k;
        // Feedback term of step k
        assign fb[k] = stage[k][CRC_W-1] ^ byte_in[BIT_IDX];
        // Shift and inject feedback at bit 0 and at each polynomial tap
        for (genvar i = 0; i < CRC_W; i++) begin : g_bit
            if (i == 0) begin : g_lsb
                assign stage[k+1][i] = fb[k] & POLY[0];
            end else begin : g_up
                assign stage[k+1][i] = stage[k][i-1] ^ (fb[k] & POLY[i]);
            end
        end
    end

    assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/crc16_state_reg.sv
`timescale 1ns/1ps
// Code register with seed preload, data fold and check fold.
// Assumes op comes from the decoder and so carries at most one operation.
module crc16_state_reg
    import crc16_pkg::*;
#(
    parameter logic [CRC_W-1:0] SEED = 16'hFFFF
) (
    input  logic    clk,
    input  logic    rst_n,
    input  crc_op_e op,
    input  crc_t    nxt_data,
    input  crc_t    nxt_check,
    output crc_t    crc_q
);
    // Register update: reset and clear preload the seed, folds load their result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= SEED;
        end else begin
            case (op)
                OP_CLEAR: crc_q <= SEED;
                OP_DATA:  crc_q <= nxt_data;
                OP_CHECK: crc_q <= nxt_check;
                default:  crc_q <= crc_q;
            endcase
        end
    end

    // R1
    reset_seed_chk: assert property (@(posedge clk) !rst_n |=> crc_q == SEED);

    // R2
    clear_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_CLEAR |=> crc_q == SEED);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == OP_NONE |=> $stable(crc_q));
endmodule

// File: rtl/crc16_port_unit.sv
`timescale 1ns/1ps
// Top of the CRC16 peripheral: decoder, two byte-fold networks (LSb-first
// for data, MSb-first for check), the code register and the read mux.
// Assumes single-cycle bus accesses with combinational read data.
module crc16_port_unit
    import crc16_pkg::*;
#(
    parameter int               ADDR_W   = 3,
    parameter int               CLR_ADDR = 0,
    parameter int               DAT_ADDR = 2,
    parameter int               CHK_ADDR = 4,
    parameter logic [CRC_W-1:0] POLY     = 16'h1021,
    parameter logic [CRC_W-1:0] SEED     = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    crc_op_e op;
    logic    rd_lo, rd_hi;
    crc_t    crc_q, nxt_data, nxt_check;

    crc16_bus_decode #(
        .ADDR_W(ADDR_W), .CLR_ADDR(CLR_ADDR),
        .DAT_ADDR(DAT_ADDR), .CHK_ADDR(CHK_ADDR)
    ) u_dec (
        .en(bus_en), .we(bus_we), .addr(bus_addr),
        .op(op), .rd_lo(rd_lo), .rd_hi(rd_hi)
    );

    crc16_byte_fold #(.POLY(POLY), .MSB_FIRST(1'b0)) u_fold_data (
        .crc_in(crc_q), .byte_in(bus_wdata), .crc_out(nxt_data)
    );

    crc16_byte_fold #(.POLY(POLY), .MSB_FIRST(1'b1)) u_fold_check (
        .crc_in(crc_q), .byte_in(bus_wdata), .crc_out(nxt_check)
    );

    crc16_state_reg #(.SEED(SEED)) u_reg (
        .clk(clk), .rst_n(rst_n), .op(op),
        .nxt_data(nxt_data), .nxt_check(nxt_check), .crc_q(crc_q)
    );

    // Read mux: one byte lane of the register, zero otherwise
    always_comb begin
        bus_rdata = 8'h00;
        if (rd_lo)      bus_rdata = crc_q[7:0];
        else if (rd_hi) bus_rdata = crc_q[15:8];
    end

    // R9
    rdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_en && !bus_we) |-> bus_rdata == 8'h00);

    // R6
    read_no_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo || rd_hi) |-> op == OP_NONE);

    // R4
    check_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CHECK && bus_wdata == crc_q[15:8])
        |=> crc_q == {$past(crc_q[7:0]), 8'h00});
endmodule

// File: tb/sim_crc16_port_unit.sv
`timescale 1ns/1ps
// Bench: behavioural bit-serial model of the code register, compared after
// every bus operation through the data-port reads.
module sim_crc16_port_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    logic [15:0] model = 16'hFFFF;

    always #2 clk = ~clk;

    crc16_port_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [15:0] ser(input logic [15:0] c, input logic [7:0] b, input bit msb);
        for (int k = 0; k < 8; k++) begin
            logic d, f;
            d = msb ? b[7-k] : b[k];
            f = c[15] ^ d;
            c = c << 1;
            if (f) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    task automatic cmp16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        case (a)
            3'd0:       model = 16'hFFFF;
            3'd2, 3'd3: model = ser(model, d, 1'b0);
            3'd4:       model = ser(model, d, 1'b1);
            default:    ;
        endcase
    endtask

    task automatic rd(output logic [15:0] v);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 3'd2;
        #0.5 v[7:0] = bus_rdata;
        bus_addr = 3'd3;
        #0.5 v[15:8] = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic check_model(input string req);
        logic [15:0] v;
        rd(v);
        cmp16(req, v, model);
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v, good;
        logic [7:0]  msg [4];
        logic [7:0]  q;
        repeat (3) @(negedge clk);
        rd(v); cmp16("R1 reset seed", v, 16'hFFFF);
        rst_n = 1'b1;

        // R3: single bytes with several patterns
        wr(3'd2, 8'h00); check_model("R3 byte 00");
        wr(3'd3, 8'hFF); check_model("R3 byte FF via addr 3");
        wr(3'd2, 8'h01); check_model("R3 byte 01");
        wr(3'd2, 8'h80); check_model("R3 byte 80");
        for (int i = 0; i < 9; i++) begin
            wr(3'd2, 8'h31 + 8'(i)); check_model("R3 ascii run");
        end

        // R6: repeated reads leave the value
        rd(v); rd(good); cmp16("R6 read no side effect", good, v);
        @(negedge clk); rd(good); cmp16("R6 read stable next cycle", good, model);

        // R7: unmapped writes and idle cycles
        foreach (q[i]) ;
        wr(3'd1, 8'hA5); wr(3'd5, 8'h5A); wr(3'd6, 8'h3C); wr(3'd7, 8'hC3);
        check_model("R7 unmapped writes ignored");
        @(negedge clk); bus_en = 1'b0; bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h77;
        @(negedge clk); bus_we = 1'b0;
        check_model("R7 no strobe hold");

        // R9: rdata quiet when not reading the data pair
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 3'd4;
        #0.5 cmp16("R9 read of check port", {8'h00, bus_rdata}, 16'h0000);
        bus_en = 1'b0; bus_addr = 3'd2;
        #0.5 cmp16("R9 bus idle", {8'h00, bus_rdata}, 16'h0000);

        // R2: clear port
        wr(3'd0, 8'h12); check_model("R2 clear");
        rd(v); cmp16("R2 clear absolute", v, 16'hFFFF);

        // R4: check-port byte order
        wr(3'd4, 8'h6B); check_model("R4 check byte msb first");
        wr(3'd4, 8'h01); check_model("R4 check byte 01");

        // R5: zero residue after appending the code, several lengths
        for (int n = 1; n <= 6; n++) begin
            wr(3'd0, 8'h00);
            for (int j = 0; j < n; j++) wr(3'd2, 8'((n * 37 + j * 91) ^ 8'h5C));
            good = model;
            wr(3'd4, good[15:8]);
            check_model("R4 high byte cancels");
            wr(3'd4, good[7:0]);
            rd(v); cmp16("R5 zero residue", v, 16'h0000);
        end

        // R8: each single-bit flip in a 4-byte message leaves a nonzero residue
        msg[0] = 8'hDE; msg[1] = 8'hAD; msg[2] = 8'h10; msg[3] = 8'h42;
        good = 16'hFFFF;
        for (int j = 0; j < 4; j++) good = ser(good, msg[j], 1'b0);
        for (int b = 0; b < 32; b++) begin
            wr(3'd0, 8'h00);
            for (int j = 0; j < 4; j++) begin
                q = msg[j];
                if (b / 8 == j) q[b % 8] = ~q[b % 8];
                wr(3'd2, q);
            end
            wr(3'd4, good[15:8]); wr(3'd4, good[7:0]);
            rd(v);
            cmp16("R8 flip residue model", v, model);
            checks++;
            if (v == 16'h0000) begin
                fails++;
                $display("FAIL R8 flip %0d actual=%h expected=nonzero", b, v);
            end
        end

        // R1: reset in the middle of a run
        wr(3'd2, 8'h9A);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; model = 16'hFFFF;
        check_model("R1 mid-run reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule